// File: doc/BRIEF.md
# Multichannel SAR ADC Sequencing Controller

This block drives a successive-approximation analog-to-digital converter through one single-shot conversion at a time. Software reaches it over a plain 32-bit register bus with four registers: the conversion result, a busy flag, a control word and a power-up delay. When the control word is written with its power bit set, the block powers the converter, routes the selected analog input and waits a programmable number of converter clocks. It then resolves the result one bit per clock, from the most significant bit down.

On each step the block drives a trial code to an external DAC and reads back a single comparator decision. The decision tells it whether the analog input is at or above the trial level, and so whether the trial bit stays set. When the last bit is decided, the result is latched. If interrupts are enabled, an interrupt flag in the control word is set and the interrupt line rises. Writing zero to the control word powers the converter down and stops any activity. The comparator, the sample-and-hold and the clock source are outside the block, and the block clock serves as the converter clock.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the status register reads 0, the delay register reads 8, the result reads 0, and `irq` and `adc_pwr` are low.
- R2: The control word (byte offset 0x08) holds the channel in bits [2:0], power in bit 3, interrupt enable in bit 5 and interrupt flag in bit 6. All other bits read as zero. The delay register (offset 0x0C) keeps only its low 6 bits.
- R3: A control write with bit 3 set while idle starts a conversion on the written channel. `adc_chan` shows that channel, and the block stays busy for exactly D + RES clocks, where D is the delay register value.
- R4: The result equals the analog level of the selected channel, with the DAC code compared against it by the comparator (high when input >= code).
- R5: The result reads at offset 0x00 in bits [RES-1:0], and all higher bits read as zero.
- R6: At the end of a conversion with interrupt enable set, bit 6 of the control word and `irq` go high. They stay high until the next accepted control write, which clears them. With interrupt enable clear, neither is set.
- R7: A control write with bit 3 clear takes effect even while busy. It drops `adc_pwr`, ends the conversion at once, and no interrupt follows.
- R8: A control write with bit 3 set while busy is ignored. The control fields are unchanged, and the running conversion completes on its original channel.
- R9: The first trial code of a conversion is half scale (only bit RES-1 set), and the trial bit moves one position lower per clock.
- R10: Bit 0 of the status register (offset 0x04) reads 1 while a conversion or its delay is in progress, and 0 otherwise. Register reads return data one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and converter clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_re` |
| adc_pwr | output | 1 | Converter power enable |
| adc_chan | output | 3 | Selected analog input |
| dac_code | output | RES | Trial code to the DAC |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Some properties are checked by the assertions on every cycle. While busy, the converter stays powered and the channel does not move. Only one trial bit is active during stepping, each conversion starts at half scale, the interrupt never appears without its enable, and a power-off write always leaves the block idle on the next clock. Other behaviours only the bench scenarios can show: the exact result for each analog level, swept over every code on rotating channels; the busy length for several delay values; the sticky flag and how it clears; and the rejected mid-conversion write.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int REG_AW = 4;
  localparam int CH_W   = 3;

  localparam logic [REG_AW-1:0] OFF_RESULT = 4'h0;
  localparam logic [REG_AW-1:0] OFF_STATUS = 4'h4;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 4'h8;
  localparam logic [REG_AW-1:0] OFF_DELAY  = 4'hC;

  localparam int CTL_PWR = 3;
  localparam int CTL_IEN = 5;
  localparam int CTL_IST = 6;

  typedef struct packed {
    logic            ist;
    logic            ien;
    logic            pwr;
    logic [CH_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  output logic             go,
  output logic             waiting
);
  logic [DLY_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = waiting && (cnt == DLY_W'(1));
  assign go = !abort && ((start && (dly == '0)) || last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (abort) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (start && (dly != '0)) begin
      waiting <= 1'b1;
      cnt     <= dly;
    end else if (last_tick) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (waiting) begin
      cnt <= cnt - DLY_W'(1);
    end
  end

  // R3: the delay counter is never empty while waiting
  a_r3_wait_nonzero: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (cnt != '0));
  // R7: an abort leaves the delay stage idle
  a_r7_wait_abort: assert property (@(posedge clk) disable iff (rst)
    abort |=> !waiting);
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic           cmp_hi,
  output logic           active,
  output logic [RES-1:0] code,
  output logic [RES-1:0] result,
  output logic           done
);
  localparam logic [RES-1:0] TOP = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] mask;
  logic [RES-1:0] kept;
  logic [RES-1:0] mask_nx;

  assign kept    = cmp_hi ? code : (code & ~mask);
  assign mask_nx = mask >> 1;
  assign done    = active && mask[0] && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      code   <= '0;
      mask   <= '0;
      result <= '0;
    end else if (abort) begin
      active <= 1'b0;
      code   <= '0;
      mask   <= '0;
    end else if (go) begin
      active <= 1'b1;
      code   <= TOP;
      mask   <= TOP;
    end else if (active) begin
      if (mask[0]) begin
        active <= 1'b0;
        code   <= kept;
        mask   <= '0;
        result <= kept;
      end else begin
        mask <= mask_nx;
        code <= kept | mask_nx;
      end
    end
  end

  // R9: every conversion opens at half scale
  a_r9_half_scale: assert property (@(posedge clk) disable iff (rst)
    (go && !abort) |=> (code == TOP));
  // R9: exactly one trial bit while stepping
  a_r9_one_trial: assert property (@(posedge clk) disable iff (rst)
    active |-> ($countones(mask) == 1));
  // R4: bits above the trial bit are never altered by a step
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (active && !mask[0] && !abort) |=> ((code & ~(($past(mask) << 1) - RES'(1))) ==
                                         ($past(code) & ~(($past(mask) << 1) - RES'(1)))));
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES      = 10,
  parameter int DLY_W    = 6,
  parameter int DLY_INIT = 8,
  parameter int DW       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES-1:0]    result,
  output logic [DW-1:0]     rdata,
  output ctrl_t             ctrl,
  output logic [DLY_W-1:0]  dly,
  output logic              start,
  output logic              abort
);
  logic ctrl_wr;
  logic ctrl_ok;

  assign ctrl_wr = we && (addr == OFF_CTRL);
  assign start   = ctrl_wr && wdata[CTL_PWR] && !busy;
  assign abort   = ctrl_wr && !wdata[CTL_PWR];
  assign ctrl_ok = start || abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_ok) begin
      ctrl.chan <= wdata[CH_W-1:0];
      ctrl.pwr  <= wdata[CTL_PWR];
      ctrl.ien  <= wdata[CTL_IEN];
      ctrl.ist  <= 1'b0;
    end else if (done && ctrl.ien) begin
      ctrl.ist <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly <= DLY_W'(DLY_INIT);
    end else if (we && (addr == OFF_DELAY)) begin
      dly <= wdata[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (addr)
        OFF_RESULT: rdata <= {{(DW-RES){1'b0}}, result};
        OFF_STATUS: rdata <= {{(DW-1){1'b0}}, busy};
        OFF_CTRL:   rdata <= {{(DW-7){1'b0}}, ctrl.ist, ctrl.ien, 1'b0, ctrl.pwr, ctrl.chan};
        OFF_DELAY:  rdata <= {{(DW-DLY_W){1'b0}}, dly};
        default:    rdata <= '0;
      endcase
    end
  end

  // R6: the flag is only raised with its enable
  a_r6_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
    ctrl.ist |-> ctrl.ien);
  // R8: a power-on write while busy leaves the channel alone
  a_r8_chan_held: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr && wdata[CTL_PWR]) |=> $stable(ctrl.chan));
  // R7: a power-off write always lands
  a_r7_pwr_off: assert property (@(posedge clk) disable iff (rst)
    abort |=> !ctrl.pwr);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int RES      = 10,
  parameter int DLY_W    = 6,
  parameter int DLY_INIT = 8,
  parameter int DW       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              adc_pwr,
  output logic [CH_W-1:0]   adc_chan,
  output logic [RES-1:0]    dac_code,
  input  logic              cmp_hi,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [DLY_W-1:0] dly;
  logic             start, abort, go, waiting, active, done, busy;
  logic [RES-1:0]   result;

  assign busy     = waiting || active;
  assign adc_pwr  = ctrl.pwr;
  assign adc_chan = ctrl.chan;
  assign irq      = ctrl.ist;

  sar_regs #(.RES(RES), .DLY_W(DLY_W), .DLY_INIT(DLY_INIT), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .done(done), .result(result),
    .rdata(reg_rdata), .ctrl(ctrl), .dly(dly), .start(start), .abort(abort)
  );

  sar_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .dly(dly),
    .go(go), .waiting(waiting)
  );

  sar_approx #(.RES(RES)) u_approx (
    .clk(clk), .rst(rst), .go(go), .abort(abort), .cmp_hi(cmp_hi),
    .active(active), .code(dac_code), .result(result), .done(done)
  );

  // R3: the converter is powered for the whole conversion
  a_r3_busy_powered: assert property (@(posedge clk) disable iff (rst)
    busy |-> adc_pwr);
  // R3: delay stage and stepping stage never overlap
  a_r3_stages_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(waiting && active));
  // R8: channel is steady across a busy period
  a_r8_chan_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(adc_chan));
endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int RES = 10;
  localparam int TCLK = 10;
  localparam logic [RES-1:0] FULL = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adc_pwr, irq, cmp_hi;
  logic [2:0]  adc_chan;
  logic [RES-1:0] dac_code;
  logic [RES-1:0] ch_v [0:7];

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(TCLK/2) clk = ~clk;

  assign cmp_hi = (ch_v[adc_chan] >= dac_code);

  sar_seq_ctrl #(.RES(RES)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_pwr(adc_pwr),
    .adc_chan(adc_chan), .dac_code(dac_code), .cmp_hi(cmp_hi), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    for (int i = 0; i < 8; i++) ch_v[i] = RES'(i * 97 + 5);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h8, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 status", d, 0);
    rd(4'hC, d); chk("R1 delay", d, 8);
    rd(4'h0, d); chk("R1 result", d, 0);
    chk("R1 irq/pwr", {irq, adc_pwr}, 0);

    // R2 field layout and masking
    wr(4'h8, 32'hFFFF_FF35); rd(4'h8, d); chk("R2 ctrl fields", d, 32'h25);
    wr(4'hC, 32'hFFFF_FFC5); rd(4'hC, d); chk("R2 delay mask", d, 32'h05);

    // R3/R9 busy length over several delays, half-scale first trial
    foreach (ch_v[k]) ch_v[k] = RES'(300);
    for (int di = 0; di < 5; di++) begin
      int dv;
      dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 8 : (di == 3) ? 17 : 63;
      wr(4'hC, dv);
      wr(4'h8, 32'h28 | (di & 7));
      if (dv == 0) chk("R9 first trial", dac_code, {1'b1, {(RES-1){1'b0}}});
      chk("R3 channel out", adc_chan, di & 7);
      wait_irq(n);
      chk("R3 busy length", n, dv + RES);
      rd(4'h0, d); chk("R4 result", d, 300);
    end

    // R10 status busy mid-conversion
    wr(4'hC, 20);
    wr(4'h8, 32'h28);
    rd(4'h4, d); chk("R10 busy high", d, 1);
    wait_irq(n);
    rd(4'h4, d); chk("R10 busy low", d, 0);

    // R6 sticky flag and clear; no flag without enable
    rd(4'h8, d); chk("R6 flag set", d, 32'h68);
    repeat (10) @(negedge clk);
    chk("R6 irq sticky", irq, 1);
    wr(4'h8, 32'h0); chk("R6 irq cleared", irq, 0);
    wr(4'hC, 0);
    wr(4'h8, 32'h0B);
    repeat (RES + 4) @(negedge clk);
    chk("R6 no irq without enable", irq, 0);
    rd(4'h8, d); chk("R6 no flag without enable", d, 32'h0B);

    // R8 power-on write while busy ignored
    ch_v[2] = RES'(777); ch_v[5] = RES'(11);
    wr(4'hC, 20);
    wr(4'h8, 32'h2A);
    wr(4'h8, 32'h0D);
    rd(4'h8, d); chk("R8 ctrl unchanged", d, 32'h2A);
    wait_irq(n);
    rd(4'h0, d); chk("R8 original channel result", d, 777);

    // R7 power-off while busy
    wr(4'hC, 30);
    wr(4'h8, 32'h2A);
    wr(4'h8, 32'h0);
    chk("R7 pwr dropped", adc_pwr, 0);
    rd(4'h4, d); chk("R7 idle", d, 0);
    repeat (50) @(negedge clk);
    chk("R7 no irq", irq, 0);

    // R4/R5 full sweep over every code on rotating channels
    wr(4'hC, 0);
    for (int v = 0; v < (1 << RES); v++) begin
      for (int k = 0; k < 8; k++) ch_v[k] = RES'(~v);
      ch_v[v % 8] = RES'(v);
      wr(4'h8, 32'h28 | (v % 8));
      wait_irq(n);
      rd(4'h0, d);
      chk("R4 R5 sweep result", d, v);
    end
    chk("R5 full scale", d, {22'b0, FULL});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule